// File: doc/BRIEF.md
# Per-Master Bus Timeout Monitor

This block watches a set of master interfaces on an on-chip interconnect and reports when a transaction stalls. Each master has three handshake signals: a request valid, a request accepted and a response valid. For every master the monitor keeps two independent counters, one for each phase of a transaction. The first counts the cycles a request waits before the slave accepts it. The second counts the cycles between acceptance and the response.

A single threshold input sets how many stalled cycles make a timeout, and it applies to both phases. Each phase has its own sticky status vector with one bit per master. A combined error output is high whenever any status bit is set. Software handles a timeout by writing a clear strobe with a 4-bit unlock key. Only the key value 0xA resets the counters, the phase tracking and both status vectors. Writes that carry any other key value are ignored.

Top module: `bus_timeout_monitor`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, both status vectors and the error output are zero.
- R2: For master i, bit i of the request-phase status vector sets at the clock edge that ends the threshold-th consecutive cycle in which req_valid[i] is high and req_accept[i] is low.
- R3: A cycle with req_valid[i] and req_accept[i] both high, or with req_valid[i] low, returns the request-phase count of master i to zero. A request accepted before the threshold is reached therefore flags nothing.
- R4: A cycle with req_valid[i] and req_accept[i] both high marks master i as outstanding. Bit i of the response-phase status vector sets at the edge that ends the threshold-th consecutive outstanding cycle with rsp_valid[i] low, counted from the cycle after acceptance. rsp_valid[i] ends the outstanding state and zeroes the count.
- R5: The masters and the two phases are independent. An event on one master or phase sets only its own bit.
- R6: A status bit stays set until a valid clear. A counter that reaches the threshold holds there and does not wrap.
- R7: A cycle with clr_wr high and clr_key equal to 4'hA clears both status vectors, every counter and every outstanding mark at the next edge. A clear overrides a timeout in the same cycle, and counting restarts from zero afterwards.
- R8: A cycle with clr_wr high and clr_key not equal to 4'hA has no effect on the status vectors or the counters.
- R9: err_out equals the OR of all bits of both status vectors in the same cycle (default ERR_PIPE = 0).
- R10: A threshold of zero disables timeout detection. No status bit sets while it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_MASTERS | Request valid for each master |
| req_accept | input | NUM_MASTERS | Slave has accepted the request of each master |
| rsp_valid | input | NUM_MASTERS | Response valid for each master |
| threshold | input | CNT_W | Timeout limit in cycles; 0 disables detection |
| clr_wr | input | 1 | Clear write strobe |
| clr_key | input | KEY_W | Key that comes with the clear write |
| acc_to_stat | output | NUM_MASTERS | Sticky request-to-accept timeout flags |
| rsp_to_stat | output | NUM_MASTERS | Sticky accept-to-response timeout flags |
| err_out | output | 1 | Combined timeout error |

## Verification
The hardest state to reach from the ports is a clear that lands partway through a pending wait. Reaching it requires a live counter that is neither zero nor saturated at the moment the key matches. Only then can the bench show that counting restarts from zero and does not carry over. The stimulus holds a request for three cycles, pulses the correct key, and checks that the flag appears exactly a full threshold later. A behavioural model compared every cycle also runs through long random traffic, where accepts, responses and keyed clears land in the same cycles. In that run the priority between a clear, an acceptance and a timeout is tested in many combinations.

// File: rtl/btm_pkg.sv
package btm_pkg;
   typedef enum logic [0:0] {
      PH_REQ = 1'b0,
      PH_RSP = 1'b1
   } btm_phase_e;

   function automatic logic btm_key_match(input logic wr, input logic [3:0] key,
                                          input logic [3:0] want);
      return wr && (key == want);
   endfunction
endpackage

// File: rtl/btm_phase_counter.sv
module btm_phase_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] threshold,
   output logic             hit
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt;
   logic             below;
   logic [EXT_W-1:0] next_ext;

   assign below    = cnt < threshold;
   assign next_ext = {1'b0, cnt} + EXT_W'(1);
   // flag on the step that lands exactly on the limit
   assign hit      = run && below && (next_ext == {1'b0, threshold});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || !run) begin
         cnt <= '0;
      end else if (below) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/btm_master_lane.sv
module btm_master_lane #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             req_valid,
   input  logic             req_accept,
   input  logic             rsp_valid,
   input  logic [CNT_W-1:0] threshold,
   output logic             acc_hit,
   output logic             rsp_hit
);
   logic outstanding;
   logic take;
   logic acc_run;
   logic rsp_run;

   assign take    = req_valid && req_accept;
   assign acc_run = req_valid && !req_accept;
   assign rsp_run = outstanding && !rsp_valid && !take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
      end else if (clear) begin
         outstanding <= 1'b0;
      end else if (take) begin
         outstanding <= 1'b1;
      end else if (rsp_valid) begin
         outstanding <= 1'b0;
      end
   end

   btm_phase_counter #(.CNT_W(CNT_W)) u_req_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .run       (acc_run),
      .threshold (threshold),
      .hit       (acc_hit)
   );

   btm_phase_counter #(.CNT_W(CNT_W)) u_rsp_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .run       (rsp_run),
      .threshold (threshold),
      .hit       (rsp_hit)
   );
endmodule

// File: rtl/btm_status.sv
module btm_status #(
   parameter int NUM_MASTERS = 4,
   parameter bit ERR_PIPE    = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic [NUM_MASTERS-1:0] acc_hit,
   input  logic [NUM_MASTERS-1:0] rsp_hit,
   output logic [NUM_MASTERS-1:0] acc_stat,
   output logic [NUM_MASTERS-1:0] rsp_stat,
   output logic                   err
);
   logic any_set;

   for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            acc_stat[g] <= 1'b0;
            rsp_stat[g] <= 1'b0;
         end else begin
            if (acc_hit[g]) acc_stat[g] <= 1'b1;
            if (rsp_hit[g]) rsp_stat[g] <= 1'b1;
         end
      end
   end

   assign any_set = (|acc_stat) || (|rsp_stat);

   if (ERR_PIPE) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= any_set;
      end
      assign err = err_q;
   end else begin : g_err_comb
      assign err = any_set;
   end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
   parameter int          NUM_MASTERS = 4,
   parameter int          CNT_W       = 8,
   parameter int          KEY_W       = 4,
   parameter logic [3:0]  CLEAR_KEY   = 4'hA,
   parameter bit          ERR_PIPE    = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_valid,
   input  logic [NUM_MASTERS-1:0] req_accept,
   input  logic [NUM_MASTERS-1:0] rsp_valid,
   input  logic [CNT_W-1:0]       threshold,
   input  logic                   clr_wr,
   input  logic [KEY_W-1:0]       clr_key,
   output logic [NUM_MASTERS-1:0] acc_to_stat,
   output logic [NUM_MASTERS-1:0] rsp_to_stat,
   output logic                   err_out
);
   import btm_pkg::*;

   if (NUM_MASTERS < 1) begin : g_bad_masters
      $error("NUM_MASTERS must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (KEY_W != 4) begin : g_bad_key
      $error("KEY_W must be 4");
   end

   logic                   clear;
   logic [NUM_MASTERS-1:0] acc_hit;
   logic [NUM_MASTERS-1:0] rsp_hit;

   assign clear = btm_key_match(clr_wr, clr_key, CLEAR_KEY);

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_lane
      btm_master_lane #(.CNT_W(CNT_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (clear),
         .req_valid  (req_valid[m]),
         .req_accept (req_accept[m]),
         .rsp_valid  (rsp_valid[m]),
         .threshold  (threshold),
         .acc_hit    (acc_hit[m]),
         .rsp_hit    (rsp_hit[m])
      );
   end

   btm_status #(.NUM_MASTERS(NUM_MASTERS), .ERR_PIPE(ERR_PIPE)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .acc_hit  (acc_hit),
      .rsp_hit  (rsp_hit),
      .acc_stat (acc_to_stat),
      .rsp_stat (rsp_to_stat),
      .err      (err_out)
   );
endmodule

// File: rtl/bus_timeout_monitor_chk.sv
module bus_timeout_monitor_chk #(
   parameter int          NUM_MASTERS = 4,
   parameter int          CNT_W       = 8,
   parameter int          KEY_W       = 4,
   parameter logic [3:0]  CLEAR_KEY   = 4'hA,
   parameter bit          ERR_PIPE    = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] req_valid,
   input logic [NUM_MASTERS-1:0] req_accept,
   input logic [NUM_MASTERS-1:0] rsp_valid,
   input logic [CNT_W-1:0]       threshold,
   input logic                   clr_wr,
   input logic [KEY_W-1:0]       clr_key,
   input logic [NUM_MASTERS-1:0] acc_to_stat,
   input logic [NUM_MASTERS-1:0] rsp_to_stat,
   input logic                   err_out
);
   logic key_ok;
   assign key_ok = clr_wr && (clr_key == CLEAR_KEY);

   // R2
   acc_rise_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_to_stat & ~$past(acc_to_stat)) & ~$past(req_valid & ~req_accept)) == '0);

   // R6
   acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_ok |=> ((acc_to_stat & $past(acc_to_stat)) == $past(acc_to_stat)));

   // R6
   rsp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_ok |=> ((rsp_to_stat & $past(rsp_to_stat)) == $past(rsp_to_stat)));

   // R7
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_ok |=> (acc_to_stat == '0 && rsp_to_stat == '0));

   // R10
   zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (threshold == '0) |=> (((acc_to_stat & ~$past(acc_to_stat)) == '0) &&
                             ((rsp_to_stat & ~$past(rsp_to_stat)) == '0)));

   if (ERR_PIPE) begin : g_err_late
      // R9
      err_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (err_out == ($past(|acc_to_stat) || $past(|rsp_to_stat))));
   end else begin : g_err_now
      // R9
      err_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
         err_out == ((|acc_to_stat) || (|rsp_to_stat)));
   end
endmodule

bind bus_timeout_monitor bus_timeout_monitor_chk #(
   .NUM_MASTERS (NUM_MASTERS),
   .CNT_W       (CNT_W),
   .KEY_W       (KEY_W),
   .CLEAR_KEY   (CLEAR_KEY),
   .ERR_PIPE    (ERR_PIPE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_accept  (req_accept),
   .rsp_valid   (rsp_valid),
   .threshold   (threshold),
   .clr_wr      (clr_wr),
   .clr_key     (clr_key),
   .acc_to_stat (acc_to_stat),
   .rsp_to_stat (rsp_to_stat),
   .err_out     (err_out)
);

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;
   localparam int N  = 4;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  req_valid, req_accept, rsp_valid;
   logic [CW-1:0] threshold;
   logic          clr_wr;
   logic [3:0]    clr_key;
   logic [N-1:0]  acc_to_stat, rsp_to_stat;
   logic          err_out;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // behavioural model state
   int m_rc [N];
   int m_ac [N];
   bit m_out[N];
   logic [N-1:0] m_acc, m_rsp;

   always #2 clk = ~clk;

   bus_timeout_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
      .rsp_valid(rsp_valid), .threshold(threshold), .clr_wr(clr_wr), .clr_key(clr_key),
      .acc_to_stat(acc_to_stat), .rsp_to_stat(rsp_to_stat), .err_out(err_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // reference model, updated on every rising edge
   always @(posedge clk) begin
      int thr;
      cycles++;
      thr = int'(threshold);
      if (!rst_n || (clr_wr && clr_key == 4'hA)) begin
         for (int i = 0; i < N; i++) begin
            m_rc[i] = 0; m_ac[i] = 0; m_out[i] = 1'b0;
         end
         m_acc = '0; m_rsp = '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (req_valid[i] && !req_accept[i]) begin
               if (m_rc[i] < thr) begin
                  if (m_rc[i] + 1 == thr) m_acc[i] = 1'b1;
                  m_rc[i]++;
               end
            end else begin
               m_rc[i] = 0;
            end
            if (req_valid[i] && req_accept[i]) begin
               m_out[i] = 1'b1; m_ac[i] = 0;
            end else if (m_out[i] && rsp_valid[i]) begin
               m_out[i] = 1'b0; m_ac[i] = 0;
            end else if (m_out[i]) begin
               if (m_ac[i] < thr) begin
                  if (m_ac[i] + 1 == thr) m_rsp[i] = 1'b1;
                  m_ac[i]++;
               end
            end else begin
               m_ac[i] = 0;
            end
         end
      end
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R4 model acc_to_stat", 32'(acc_to_stat), 32'(m_acc));
         chk("R2/R4 model rsp_to_stat", 32'(rsp_to_stat), 32'(m_rsp));
         chk("R9 model err_out", 32'(err_out), 32'(|{m_acc, m_rsp}));
      end
   end

   initial begin
      wait (cycles > 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   task automatic idle_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clear(input logic [3:0] key);
      clr_wr = 1'b1; clr_key = key;
      @(negedge clk);
      clr_wr = 1'b0; clr_key = 4'h0;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = '0; req_accept = '0; rsp_valid = '0;
      threshold = 8'd5; clr_wr = 1'b0; clr_key = 4'h0;
      idle_n(3);
      // R1 during reset
      chk("R1 acc in reset", 32'(acc_to_stat), 0);
      chk("R1 err in reset", 32'(err_out), 0);
      rst_n = 1'b1;
      idle_n(3);
      chk("R1 acc after reset", 32'(acc_to_stat), 0);
      chk("R1 rsp after reset", 32'(rsp_to_stat), 0);

      // R2: master 0 waits for 5 cycles
      req_valid[0] = 1'b1;
      idle_n(4);
      chk("R2 before limit", 32'(acc_to_stat[0]), 0);
      idle_n(1);
      chk("R2 at limit", 32'(acc_to_stat[0]), 1);
      chk("R9 err follows", 32'(err_out), 1);
      req_valid[0] = 1'b0;

      // R3: master 1 accepted on its 4th cycle, answered at once
      req_valid[1] = 1'b1;
      idle_n(3);
      req_accept[1] = 1'b1;
      idle_n(1);
      req_valid[1] = 1'b0; req_accept[1] = 1'b0; rsp_valid[1] = 1'b1;
      idle_n(1);
      rsp_valid[1] = 1'b0;
      idle_n(10);
      chk("R3 accept resets wait", 32'(acc_to_stat[1]), 0);
      chk("R4 answered in time", 32'(rsp_to_stat[1]), 0);

      // R4: master 2 accepted, never answered
      req_valid[2] = 1'b1; req_accept[2] = 1'b1;
      idle_n(1);
      req_valid[2] = 1'b0; req_accept[2] = 1'b0;
      idle_n(4);
      chk("R4 before limit", 32'(rsp_to_stat[2]), 0);
      idle_n(1);
      chk("R4 at limit", 32'(rsp_to_stat[2]), 1);

      // R5: only own bits
      chk("R5 acc vector", 32'(acc_to_stat), 32'h1);
      chk("R5 rsp vector", 32'(rsp_to_stat), 32'h4);

      // R6: sticky after traffic stops
      idle_n(20);
      chk("R6 acc sticky", 32'(acc_to_stat), 32'h1);
      chk("R6 rsp sticky", 32'(rsp_to_stat), 32'h4);

      // R8: wrong key ignored
      do_clear(4'h5);
      chk("R8 acc kept", 32'(acc_to_stat), 32'h1);
      chk("R8 rsp kept", 32'(rsp_to_stat), 32'h4);

      // R7: correct key clears
      do_clear(4'hA);
      chk("R7 acc cleared", 32'(acc_to_stat), 0);
      chk("R7 rsp cleared", 32'(rsp_to_stat), 0);
      chk("R9 err cleared", 32'(err_out), 0);

      // R7: clear mid-wait restarts the count
      req_valid[3] = 1'b1;
      idle_n(3);
      clr_wr = 1'b1; clr_key = 4'hA;
      idle_n(1);
      clr_wr = 1'b0; clr_key = 4'h0;
      idle_n(4);
      chk("R7 restart not early", 32'(acc_to_stat[3]), 0);
      idle_n(1);
      chk("R7 restart full limit", 32'(acc_to_stat[3]), 1);

      // R6: held wait far past 256 cycles stays saturated and set
      idle_n(300);
      chk("R6 no wrap", 32'(acc_to_stat), 32'h8);
      req_valid[3] = 1'b0;
      do_clear(4'hA);

      // R10: zero threshold disables detection
      threshold = 8'd0;
      req_valid[0] = 1'b1;
      req_valid[1] = 1'b1; req_accept[1] = 1'b1;
      idle_n(1);
      req_valid[1] = 1'b0; req_accept[1] = 1'b0;
      idle_n(30);
      chk("R10 acc quiet", 32'(acc_to_stat), 0);
      chk("R10 rsp quiet", 32'(rsp_to_stat), 0);
      req_valid[0] = 1'b0;
      threshold = 8'd5;
      do_clear(4'hA);

      // mixed traffic against the model
      for (int k = 0; k < 3000; k++) begin
         req_valid  = N'($urandom);
         req_accept = N'($urandom) & N'($urandom);
         rsp_valid  = N'($urandom) & N'($urandom) & N'($urandom);
         if (($urandom % 97) == 0) threshold = CW'(($urandom % 7));
         clr_wr  = (($urandom % 40) == 0);
         clr_key = (($urandom % 2) == 0) ? 4'hA : 4'($urandom);
         idle_n(1);
      end
      clr_wr = 1'b0; req_valid = '0; req_accept = '0; rsp_valid = '0;
      idle_n(3);
      done = 1'b1;
      report();
   end
endmodule